// File: doc/BRIEF.md
# Guarded Watchdog Timer

This block is a watchdog counter that advances on a slow, free-running tick strobe and raises a system reset request if software fails to refresh it in time. The timeout is a power of two of tick periods, chosen by a 4-bit prescaler code held in a byte-wide control register together with an enable bit. When the count runs out, the block pulses its reset request and sets a sticky watchdog-cause flag. Software can read the flag and clear it through a small register port.

The control register cannot be rewritten freely. A build parameter picks one of two guards. The first is a two-step timed sequence: a write with both the change bit and the enable bit set opens a short window, and the write that follows inside that window takes effect. The second is a key register: writing the key byte 0xD8 there opens a window that admits exactly one control write.

Reset causes are handled separately. A power-on reset clears everything. Any other reset brings the watchdog up armed at the shortest timeout and keeps the cause flag. While the flag is set, the enable bit cannot be cleared.

Top module: `wdt_guarded`

## Requirements
- R1: Power-on reset (`por`, synchronous, active high) clears the enable bit, the prescaler code, the cause flag, the unlock window and the read data. The reset request output is low afterwards.
- R2: While enabled with code c, `rst_req` goes high for exactly one cycle in the cycle after the 2^(BASE_EXP+c)-th tick counted since the last restart. Codes above the largest supported code (9 with the fourth prescaler bit, 7 without it) behave as the largest code.
- R3: A cycle with `kick` high restarts the count from zero. No expiry is reported in the cycle that follows it.
- R4: Expiry sets the cause flag, which reads as bit 0 of the status register (address 2). Writing 1 to status bit 0 clears the flag. Writing 0 leaves it set. Only power-on reset and that write clear the flag.
- R5: `ext_rst` (synchronous, active high, non-power-on) sets the enable bit, sets the prescaler code to 0, restarts the count and closes any window. It leaves the cause flag unchanged.
- R6: While the cause flag is set, the enable bit stays 1 even after an otherwise valid write that clears it.
- R7: Timed mode (SIG_MODE=0): a control write with bit 4 (change) and bit 3 (enable) both set opens a window of WIN_CYC cycles and sets the enable bit. The prescaler code is unchanged. Bit 4 reads 1 while the window is open. The next control write inside the window loads the enable bit and the prescaler code, closes the window, and clears bit 4.
- R8: Timed mode: a control write outside a window has no effect, unless it is itself an opening write. A write to any other address while a window is open closes the window.
- R9: Key mode (SIG_MODE=1): writing 0xD8 to the key register (address 1) opens a WIN_CYC window for exactly one control write. Control writes at any other time are ignored. A key write of any other value closes the window.
- R10: Control register layout: bits 2:0 hold prescaler bits 2:0, bit 3 the enable, bit 4 the window-open/change bit, bit 5 prescaler bit 3. Bits 7:6 read 0. The key register and address 3 read 0. `bus_rdata` shows the register at `bus_addr` one cycle later.
- R11: While the enable bit is 0, ticks are not counted and `rst_req` stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| por | input | 1 | Power-on reset, synchronous, active high |
| ext_rst | input | 1 | Any other reset cause, synchronous, active high |
| tick | input | 1 | Slow timebase strobe, one clock wide per tick |
| kick | input | 1 | Refresh strobe |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 2 | Register address: 0 control, 1 key, 2 status |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Registered read data for `bus_addr` |
| rst_req | output | 1 | One-cycle system reset request on expiry |
| rst_flag | output | 1 | Watchdog-cause flag |

## Verification
The assertions assume that `tick` and `kick` are clean single-clock strobes. They also assume that `por` and `ext_rst` are synchronous levels, and that `por` is high at the first clock edge so that no check sees uninitialised state. The bench keeps to these assumptions. It drives all inputs on the falling edge, opens every test with a power-on pulse, and uses a shortened `BASE_EXP` so that every prescaler code, including the clamped ones, can run out within the cycle budget. A timed-mode instance and a key-mode instance share one stimulus bus, so each unlock style is also checked against the other instance, which must ignore it.

// File: rtl/wdt_guard_pkg.sv
package wdt_guard_pkg;
  localparam int CTRL_W  = 8;
  localparam int BIT_EN  = 3;
  localparam int BIT_CHG = 4;
  localparam int BIT_PS3 = 5;
  localparam int CODE_W  = 4;
  localparam logic [CTRL_W-1:0] UNLOCK_KEY = 8'hD8;

  typedef enum logic [1:0] {
    A_CTRL = 2'd0,
    A_KEY  = 2'd1,
    A_STAT = 2'd2,
    A_NONE = 2'd3
  } wdt_addr_e;
endpackage

// File: rtl/wdt_unlock.sv
module wdt_unlock
  import wdt_guard_pkg::*;
#(
  parameter int SIG_MODE = 0,
  parameter int WIN_CYC  = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_ctrl,
  input  logic              wr_key,
  input  logic              wr_other,
  input  logic [CTRL_W-1:0] wdata,
  output logic              win_open,
  output logic              apply,
  output logic              arm
);
  localparam int WC_W = $clog2(WIN_CYC + 1);

  logic [WC_W-1:0] win_cnt;
  logic            open_ev;
  logic            close_ev;

  assign win_open = (win_cnt != '0);
  assign apply    = wr_ctrl && win_open;

  generate
    if (SIG_MODE == 0) begin : g_timed
      assign open_ev  = wr_ctrl && !win_open && wdata[BIT_CHG] && wdata[BIT_EN];
      assign arm      = open_ev;
      assign close_ev = apply || (wr_other && win_open);
    end else begin : g_key
      assign open_ev  = wr_key && (wdata == UNLOCK_KEY);
      assign arm      = 1'b0;
      assign close_ev = apply || (wr_key && (wdata != UNLOCK_KEY));
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst)                 win_cnt <= '0;
    else if (open_ev)        win_cnt <= WC_W'(WIN_CYC);
    else if (close_ev)       win_cnt <= '0;
    else if (win_cnt != '0)  win_cnt <= win_cnt - 1'b1;
  end

  // R7: a consumed window is closed on the following cycle
  p_apply_closes_r7: assert property (@(posedge clk) disable iff (rst)
    apply |=> !win_open);

  // R8: a window only opens right after a register write
  p_open_needs_write_r8: assert property (@(posedge clk) disable iff (rst)
    $rose(win_open) |-> $past(wr_ctrl || wr_key));
endmodule

// File: rtl/wdt_cfg.sv
module wdt_cfg
  import wdt_guard_pkg::*;
#(
  parameter int HAS_PS3 = 1
) (
  input  logic              clk,
  input  logic              por,
  input  logic              ext_rst,
  input  logic              apply,
  input  logic              arm,
  input  logic [CTRL_W-1:0] wdata,
  input  logic              expire,
  input  logic              flag_clr,
  output logic              en,
  output logic [CODE_W-1:0] code,
  output logic              flag
);
  logic              en_q, flag_q;
  logic [CODE_W-1:0] code_q;
  logic              en_d, flag_d, ps3_in;
  logic [CODE_W-1:0] code_d;

  generate
    if (HAS_PS3 != 0) begin : g_ps3
      assign ps3_in = wdata[BIT_PS3];
    end else begin : g_no_ps3
      assign ps3_in = 1'b0;
    end
  endgenerate

  always_comb begin
    flag_d = flag_q;
    if (flag_clr) flag_d = 1'b0;
    if (expire)   flag_d = 1'b1;
    en_d   = en_q;
    code_d = code_q;
    if (apply) begin
      en_d   = wdata[BIT_EN];
      code_d = {ps3_in, wdata[2:0]};
    end else if (arm) begin
      en_d = 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (por) begin
      en_q   <= 1'b0;
      code_q <= '0;
      flag_q <= 1'b0;
    end else if (ext_rst) begin
      en_q   <= 1'b1;
      code_q <= '0;
    end else begin
      en_q   <= en_d | flag_d;
      code_q <= code_d;
      flag_q <= flag_d;
    end
  end

  assign en   = en_q;
  assign code = code_q;
  assign flag = flag_q;

  // R1: power-on reset leaves flag and enable clear
  p_por_clear_r1: assert property (@(posedge clk) disable iff (ext_rst)
    por |=> (!flag_q && !en_q && code_q == '0));

  // R4: the flag holds until cleared by software or power-on
  p_flag_sticky_r4: assert property (@(posedge clk) disable iff (por)
    (flag_q && !flag_clr) |=> flag_q);

  // R5: a non-power-on reset arms the fastest timeout
  p_ext_arms_r5: assert property (@(posedge clk) disable iff (por)
    ext_rst |=> (en_q && code_q == '0));

  // R6: a set flag keeps the watchdog enabled
  p_flag_forces_en_r6: assert property (@(posedge clk) disable iff (por)
    flag_q |-> en_q);
endmodule

// File: rtl/wdt_timer.sv
module wdt_timer
  import wdt_guard_pkg::*;
#(
  parameter int BASE_EXP = 11,
  parameter int MAX_CODE = 9
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tick,
  input  logic              kick,
  input  logic              en,
  input  logic [CODE_W-1:0] code,
  output logic              hit,
  output logic              rst_req
);
  localparam int CNT_W = BASE_EXP + MAX_CODE;

  logic [CNT_W-1:0]  cnt;
  logic [CNT_W-1:0]  last;
  logic [CODE_W-1:0] code_c;
  logic [CODE_W-1:0] shamt;

  always_comb begin
    code_c = (code > CODE_W'(MAX_CODE)) ? CODE_W'(MAX_CODE) : code;
    shamt  = CODE_W'(MAX_CODE) - code_c;
    last   = {CNT_W{1'b1}} >> shamt;
  end

  assign hit = en && tick && !kick && (cnt >= last);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt     <= '0;
      rst_req <= 1'b0;
    end else begin
      rst_req <= hit;
      if (!en || kick || hit) cnt <= '0;
      else if (tick)          cnt <= cnt + 1'b1;
    end
  end

  // R2: the reset request is a single-cycle pulse
  p_req_pulse_r2: assert property (@(posedge clk) disable iff (rst)
    rst_req |=> !rst_req);

  // R3: a refresh never yields an expiry on the next cycle
  p_kick_quiet_r3: assert property (@(posedge clk) disable iff (rst)
    kick |=> !rst_req);

  // R11: nothing is requested while disabled
  p_idle_quiet_r11: assert property (@(posedge clk) disable iff (rst)
    !en |=> !rst_req);
endmodule

// File: rtl/wdt_guarded.sv
module wdt_guarded
  import wdt_guard_pkg::*;
#(
  parameter int SIG_MODE = 0,
  parameter int HAS_PS3  = 1,
  parameter int BASE_EXP = 11,
  parameter int WIN_CYC  = 4
) (
  input  logic       clk,
  input  logic       por,
  input  logic       ext_rst,
  input  logic       tick,
  input  logic       kick,
  input  logic       bus_wr,
  input  logic [1:0] bus_addr,
  input  logic [7:0] bus_wdata,
  output logic [7:0] bus_rdata,
  output logic       rst_req,
  output logic       rst_flag
);
  localparam int MAX_CODE = (HAS_PS3 != 0) ? 9 : 7;

  wdt_addr_e         addr;
  logic              wr_ctrl, wr_key, wr_other, flag_clr;
  logic              win_open, apply, arm;
  logic              en, hit, flag;
  logic [CODE_W-1:0] code;
  logic              any_rst;

  assign addr     = wdt_addr_e'(bus_addr);
  assign wr_ctrl  = bus_wr && (addr == A_CTRL);
  assign wr_key   = bus_wr && (addr == A_KEY);
  assign wr_other = bus_wr && (addr != A_CTRL);
  assign flag_clr = bus_wr && (addr == A_STAT) && bus_wdata[0];
  assign any_rst  = por || ext_rst;

  wdt_unlock #(.SIG_MODE(SIG_MODE), .WIN_CYC(WIN_CYC)) u_unlock (
    .clk      (clk),
    .rst      (any_rst),
    .wr_ctrl  (wr_ctrl),
    .wr_key   (wr_key),
    .wr_other (wr_other),
    .wdata    (bus_wdata),
    .win_open (win_open),
    .apply    (apply),
    .arm      (arm)
  );

  wdt_cfg #(.HAS_PS3(HAS_PS3)) u_cfg (
    .clk      (clk),
    .por      (por),
    .ext_rst  (ext_rst),
    .apply    (apply),
    .arm      (arm),
    .wdata    (bus_wdata),
    .expire   (hit),
    .flag_clr (flag_clr),
    .en       (en),
    .code     (code),
    .flag     (flag)
  );

  wdt_timer #(.BASE_EXP(BASE_EXP), .MAX_CODE(MAX_CODE)) u_timer (
    .clk     (clk),
    .rst     (any_rst),
    .tick    (tick),
    .kick    (kick),
    .en      (en),
    .code    (code),
    .hit     (hit),
    .rst_req (rst_req)
  );

  logic [7:0] ctrl_view;
  assign ctrl_view = {2'b00, code[3], win_open, en, code[2:0]};

  always_ff @(posedge clk) begin
    if (por) begin
      bus_rdata <= '0;
    end else begin
      case (addr)
        A_CTRL:  bus_rdata <= ctrl_view;
        A_STAT:  bus_rdata <= {7'b0, flag};
        default: bus_rdata <= '0;
      endcase
    end
  end

  assign rst_flag = flag;

  // R4: the flag output only rises together with a reset request
  p_flag_with_req_r4: assert property (@(posedge clk) disable iff (any_rst)
    $rose(rst_flag) |-> rst_req);
endmodule

// File: tb/wdt_guarded_test.sv
module wdt_guarded_test;
  localparam int BEXP = 4;
  localparam logic [1:0] AC = 2'd0, AK = 2'd1, AS = 2'd2, AN = 2'd3;

  logic clk = 1'b0;
  logic por = 1'b1, ext_rst = 1'b0, tick = 1'b0, kick = 1'b0, bus_wr = 1'b0;
  logic [1:0] bus_addr = 2'd0;
  logic [7:0] bus_wdata = 8'd0;
  logic [7:0] rd_t, rd_s;
  logic req_t, req_s, flag_t, flag_s;
  int n_cmp = 0, n_bad = 0;

  always #4 clk = ~clk;

  wdt_guarded #(.SIG_MODE(0), .BASE_EXP(BEXP)) uut (
    .clk(clk), .por(por), .ext_rst(ext_rst), .tick(tick), .kick(kick),
    .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_rdata(rd_t), .rst_req(req_t), .rst_flag(flag_t));

  wdt_guarded #(.SIG_MODE(1), .BASE_EXP(BEXP)) uut_sig (
    .clk(clk), .por(por), .ext_rst(ext_rst), .tick(tick), .kick(kick),
    .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_rdata(rd_s), .rst_req(req_s), .rst_flag(flag_s));

  function automatic logic [7:0] mk(input logic en, input logic chg, input logic [3:0] c);
    return {2'b00, c[3], chg, en, c[2:0]};
  endfunction

  function automatic int lim(input int c);
    return 1 << (BEXP + ((c > 9) ? 9 : c));
  endfunction

  task automatic chk(input string what, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", what, act, exp);
    end
  endtask

  task automatic do_por();
    @(negedge clk); por = 1'b1;
    @(negedge clk); @(negedge clk); por = 1'b0;
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk); bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk); bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] vt, output logic [7:0] vs);
    @(negedge clk); bus_addr = a;
    @(negedge clk); vt = rd_t; vs = rd_s;
  endtask

  task automatic ticks(input int n);
    @(negedge clk); tick = 1'b1;
    repeat (n - 1) @(negedge clk);
    @(negedge clk); tick = 1'b0;
  endtask

  task automatic pulse_kick();
    @(negedge clk); kick = 1'b1;
    @(negedge clk); kick = 1'b0;
  endtask

  task automatic t_reset();
    logic [7:0] vt, vs;
    do_por();
    rd(AC, vt, vs);
    chk("R1 ctrl after por (timed)", vt, 8'h00);
    chk("R1 ctrl after por (key)", vs, 8'h00);
    rd(AS, vt, vs);
    chk("R1 status after por", vt, 8'h00);
    chk("R1 rst_req low", req_t, 1'b0);
    rd(AK, vt, vs);
    chk("R10 key register reads zero", vs, 8'h00);
  endtask

  task automatic t_timed_change();
    logic [7:0] vt, vs;
    do_por();
    wr(AC, 8'h18);
    rd(AC, vt, vs);
    chk("R7 window open, change bit and enable read 1", vt, mk(1, 1, 0));
    wr(AC, 8'h2A);
    rd(AC, vt, vs);
    chk("R7 R10 second write applied, change bit cleared", vt, mk(1, 0, 4'd10));
    chk("R9 key instance ignores timed sequence", vs, 8'h00);
  endtask

  task automatic t_timeout(input int c);
    logic [7:0] d;
    do_por();
    d = mk(1, 0, 4'(c));
    wr(AC, 8'h18);
    wr(AC, d);
    ticks(lim(c) - 1);
    chk($sformatf("R2 code %0d no request one tick early", c), req_t, 1'b0);
    chk($sformatf("R4 code %0d flag clear before expiry", c), flag_t, 1'b0);
    ticks(1);
    chk($sformatf("R2 code %0d request on last tick", c), req_t, 1'b1);
    chk($sformatf("R4 code %0d flag set on expiry", c), flag_t, 1'b1);
    chk("R11 disabled key instance silent", req_s, 1'b0);
    @(negedge clk);
    chk($sformatf("R2 code %0d request one cycle wide", c), req_t, 1'b0);
  endtask

  task automatic t_refresh();
    do_por();
    wr(AC, 8'h18);
    wr(AC, 8'h08);
    ticks(10);
    pulse_kick();
    ticks(lim(0) - 1);
    chk("R3 refresh restarted the count", req_t, 1'b0);
    ticks(1);
    chk("R3 expiry a full period after refresh", req_t, 1'b1);
  endtask

  task automatic t_flag();
    logic [7:0] vt, vs;
    do_por();
    wr(AC, 8'h18);
    wr(AC, 8'h08);
    ticks(lim(0));
    rd(AS, vt, vs);
    chk("R4 status bit 0 shows flag", vt, 8'h01);
    wr(AC, 8'h18);
    wr(AC, 8'h00);
    rd(AC, vt, vs);
    chk("R6 disable blocked while flag set", vt, mk(1, 0, 0));
    wr(AS, 8'h00);
    rd(AS, vt, vs);
    chk("R4 writing 0 keeps flag", vt, 8'h01);
    wr(AS, 8'h01);
    rd(AS, vt, vs);
    chk("R4 write 1 clears flag", vt, 8'h00);
    wr(AC, 8'h18);
    wr(AC, 8'h00);
    rd(AC, vt, vs);
    chk("R7 disable after flag cleared", vt, 8'h00);
    ticks(40);
    chk("R11 no request while disabled", req_t, 1'b0);
  endtask

  task automatic t_ext();
    logic [7:0] vt, vs;
    do_por();
    wr(AC, 8'h18);
    wr(AC, 8'h0A);
    ticks(lim(2));
    @(negedge clk); ext_rst = 1'b1;
    @(negedge clk); ext_rst = 1'b0;
    rd(AC, vt, vs);
    chk("R5 timed instance armed at code 0", vt, mk(1, 0, 0));
    chk("R5 key instance armed at code 0", vs, mk(1, 0, 0));
    rd(AS, vt, vs);
    chk("R5 flag kept over external reset", vt, 8'h01);
    chk("R5 key instance flag still clear", vs, 8'h00);
    ticks(lim(0) - 1);
    chk("R5 no early expiry after external reset", req_t, 1'b0);
    ticks(1);
    chk("R5 fastest timeout (timed)", req_t, 1'b1);
    chk("R5 fastest timeout (key)", req_s, 1'b1);
  endtask

  task automatic t_timed_reject();
    logic [7:0] vt, vs;
    do_por();
    wr(AC, 8'h0B);
    rd(AC, vt, vs);
    chk("R8 unguarded write ignored", vt, 8'h00);
    wr(AC, 8'h10);
    wr(AC, 8'h0B);
    rd(AC, vt, vs);
    chk("R8 change bit alone opens nothing", vt, 8'h00);
    wr(AC, 8'h18);
    repeat (4) @(negedge clk);
    wr(AC, 8'h0B);
    rd(AC, vt, vs);
    chk("R8 write after window ignored", vt, mk(1, 0, 0));
    do_por();
    wr(AC, 8'h18);
    wr(AS, 8'h00);
    wr(AC, 8'h0B);
    rd(AC, vt, vs);
    chk("R8 other-address write closes window", vt, mk(1, 0, 0));
  endtask

  task automatic t_key();
    logic [7:0] vt, vs;
    do_por();
    wr(AC, 8'h0B);
    rd(AC, vt, vs);
    chk("R9 control write without key ignored", vs, 8'h00);
    wr(AK, 8'hD8);
    wr(AC, 8'h0B);
    rd(AC, vt, vs);
    chk("R9 keyed write applied", vs, mk(1, 0, 3));
    chk("R8 key write does nothing in timed mode", vt, 8'h00);
    wr(AC, 8'h09);
    rd(AC, vt, vs);
    chk("R9 key admits only one write", vs, mk(1, 0, 3));
    wr(AK, 8'h5A);
    wr(AC, 8'h09);
    rd(AC, vt, vs);
    chk("R9 wrong key rejected", vs, mk(1, 0, 3));
    wr(AK, 8'hD8);
    repeat (4) @(negedge clk);
    wr(AC, 8'h09);
    rd(AC, vt, vs);
    chk("R9 key window expires", vs, mk(1, 0, 3));
    wr(AK, 8'hD8);
    wr(AK, 8'h00);
    wr(AC, 8'h09);
    rd(AC, vt, vs);
    chk("R9 non-key value closes window", vs, mk(1, 0, 3));
    rd(AN, vt, vs);
    chk("R10 unused address reads zero", vs, 8'h00);
  endtask

  logic done = 1'b0;

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    t_reset();
    t_timed_change();
    t_timeout(0);
    t_timeout(1);
    t_timeout(3);
    t_timeout(9);
    t_timeout(12);
    t_refresh();
    t_flag();
    t_ext();
    t_timed_reject();
    t_key();
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule